// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM's contents alive and brings the part up after power is applied. Once reset is released it holds both strobes inactive for a long settle pause. It then issues a fixed number of dummy row-strobe pulses, each followed by a precharge gap. When the last gap has elapsed it declares the memory ready. From then on it raises a refresh request at a steady interval. When the access controller grants the strobes, it performs one refresh cycle of the kind in which the column strobe leads the row strobe. In that cycle the memory's own row counter picks the row, so this block drives no address and no data.

Intervals that expire before a grant arrives are counted, so no refresh is lost while the access controller is busy. The interval timer restarts on every grant. All lengths are parameters in clock cycles: pause, wake-up count, column-to-row setup, row-strobe width, precharge, refresh interval and pending-counter width. A test can therefore shorten them.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, ras_n and cas_n are 1 and init_done, refresh_req and refresh_busy are 0.
- R2: For the first PAUSE_CYC clock edges after reset release, ras_n stays 1.
- R3: After the pause, ras_n makes exactly WAKE_CNT low pulses. Each pulse is RAS_CYC cycles low followed by RP_CYC cycles high. cas_n stays 1 for the whole power-up phase.
- R4: init_done rises at edge PAUSE_CYC + WAKE_CNT*(RAS_CYC+RP_CYC) after reset release, which is when the last precharge gap ends, and then stays 1.
- R5: refresh_req stays 0 before init_done. A grant during power-up has no effect on any output.
- R6: The first refresh_req rises REFI_CYC edges after init_done rises. Each accepted grant restarts the interval, so the next request comes REFI_CYC edges after the grant edge.
- R7: A grant is accepted when refresh_grant and refresh_req are both 1 and no refresh is in progress. From the next cycle, refresh_busy is 1 for CSR_CYC+RAS_CYC+RP_CYC cycles. During that time cas_n is 0 for CSR_CYC cycles with ras_n 1, then ras_n and cas_n are both 0 for RAS_CYC cycles, then both are 1 for RP_CYC cycles.
- R8: Each interval that expires adds one pending refresh. With two pending and the grant held, two refresh cycles run separated by one idle cycle, and refresh_req stays 1 after the first.
- R9: The pending count saturates at 2^PEND_W-1. Later expiries before service are dropped.
- R10: A grant while refresh_req is 0 leaves ras_n, cas_n and refresh_busy unchanged at 1, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_grant | input | 1 | Access controller hands the strobes to this block |
| refresh_req | output | 1 | At least one refresh is pending |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| init_done | output | 1 | Power-up sequence complete |
| refresh_busy | output | 1 | A refresh cycle owns the strobes |

## Verification
Every output is a flop, so a grant accepted at edge T shows its first effect (busy high, cas_n low) after edge T and nothing earlier. An interval expiry sets refresh_req at the same edge where the timer's zero count is seen. The bench derives each due edge from the parameters, counting edges from reset release: the strobe states during power-up, edge 60 for init_done, edge 100 for the first request, and edge 141 after a grant at 101. It samples on the falling clock edge after the edge in question. The refresh waveform is compared cycle by cycle against a table indexed by edges after the grant, and the pending and saturation cases are checked by counting row-strobe falls over a known window.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CSR,
    ST_RAS,
    ST_PRE
  } seq_st_t;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
  parameter int unsigned REFI_CYC = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic reload,
  output logic tick
);
  localparam int unsigned TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam logic [TW-1:0] TOP = TW'(REFI_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en)              cnt <= TOP;
    else if (reload || cnt == '0) cnt <= TOP;
    else                         cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/drs_pending_ctr.sv
module drs_pending_ctr #(
  parameter int unsigned PEND_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic req
);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend, pend_n;

  always_comb begin
    pend_n = pend;
    if (inc && !dec && pend != PMAX)    pend_n = pend + 1'b1;
    else if (dec && !inc && pend != '0) pend_n = pend - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      req  <= 1'b0;
    end else begin
      pend <= pend_n;
      req  <= (pend_n != '0);
    end
  end

  AST_PEND_SAT: assert property (@(posedge clk) disable iff (rst)
    (pend == PMAX && inc && !dec) |=> (pend == PMAX && req)); // R9
endmodule

// File: rtl/drs_strobe_seq.sv
module drs_strobe_seq
  import drs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned WAKE_CNT  = 8,
  parameter int unsigned CSR_CYC   = 2,
  parameter int unsigned RAS_CYC   = 5,
  parameter int unsigned RP_CYC    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic idle,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic busy
);
  localparam int unsigned LONGEST = max_of4(PAUSE_CYC, CSR_CYC, RAS_CYC, RP_CYC);
  localparam int unsigned CW = $clog2(LONGEST + 1);
  localparam int unsigned WW = $clog2(WAKE_CNT + 1);

  seq_st_t       st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [WW-1:0] wake_left, wake_left_n;
  logic          cbr, cbr_n;
  logic          done_n, busy_n;

  assign idle = (st == ST_IDLE);

  always_comb begin
    st_n        = st;
    cnt_n       = (cnt != '0) ? cnt - 1'b1 : cnt;
    wake_left_n = wake_left;
    cbr_n       = cbr;
    done_n      = init_done;
    busy_n      = busy;
    unique case (st)
      ST_PAUSE: if (cnt == '0) begin
        st_n  = ST_RAS;
        cnt_n = CW'(RAS_CYC - 1);
        cbr_n = 1'b0;
      end
      ST_IDLE: if (start) begin
        st_n   = ST_CSR;
        cnt_n  = CW'(CSR_CYC - 1);
        cbr_n  = 1'b1;
        busy_n = 1'b1;
      end
      ST_CSR: if (cnt == '0) begin
        st_n  = ST_RAS;
        cnt_n = CW'(RAS_CYC - 1);
      end
      ST_RAS: if (cnt == '0) begin
        st_n  = ST_PRE;
        cnt_n = CW'(RP_CYC - 1);
      end
      ST_PRE: if (cnt == '0) begin
        if (init_done) begin
          st_n   = ST_IDLE;
          busy_n = 1'b0;
        end else if (wake_left == WW'(1)) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          st_n        = ST_RAS;
          cnt_n       = CW'(RAS_CYC - 1);
          wake_left_n = wake_left - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PAUSE;
      cnt       <= CW'(PAUSE_CYC - 1);
      wake_left <= WW'(WAKE_CNT);
      cbr       <= 1'b0;
      init_done <= 1'b0;
      busy      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      wake_left <= wake_left_n;
      cbr       <= cbr_n;
      init_done <= done_n;
      busy      <= busy_n;
      ras_n     <= (st_n != ST_RAS);
      cas_n     <= !((st_n == ST_CSR) || (st_n == ST_RAS && cbr_n));
    end
  end

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R4
  AST_WAKE_NO_CAS: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> cas_n); // R3
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && init_done) |-> (!cas_n && $past(!cas_n))); // R7
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned WAKE_CNT  = 8,
  parameter int unsigned CSR_CYC   = 2,
  parameter int unsigned RAS_CYC   = 5,
  parameter int unsigned RP_CYC    = 3,
  parameter int unsigned REFI_CYC  = 3000,
  parameter int unsigned PEND_W    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_grant,
  output logic refresh_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic refresh_busy
);
  logic seq_idle, take, tick;

  assign take = refresh_grant && refresh_req && seq_idle;

  drs_strobe_seq #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_CNT(WAKE_CNT), .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start(take), .idle(seq_idle),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done), .busy(refresh_busy)
  );

  drs_interval_timer #(.REFI_CYC(REFI_CYC)) u_tmr (
    .clk(clk), .rst(rst), .en(init_done), .reload(take), .tick(tick)
  );

  drs_pending_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst(rst), .inc(tick), .dec(take), .req(refresh_req)
  );

  AST_NO_REQ_PREINIT: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !refresh_req); // R5
  AST_BUSY_FROM_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_busy) |-> $past(refresh_grant && refresh_req)); // R7
  AST_CAS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !refresh_busy |-> cas_n); // R10
endmodule

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int P = 20, W = 8, C = 2, R = 3, RP = 2, REFI = 40, PW = 2;
  localparam int DONE_AT = P + W * (R + RP);

  // {busy, ras_n, cas_n, req} after edges T+0 .. T+7, grant accepted at T (R7)
  localparam logic [3:0] CBR_WAVE [0:7] = '{
    4'b1100, 4'b1100, 4'b1000, 4'b1000, 4'b1000, 4'b1110, 4'b1110, 4'b0110
  };

  logic clk = 1'b0, rst = 1'b1, grant = 1'b0;
  logic req, ras_n, cas_n, init_done, busy;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P), .WAKE_CNT(W), .CSR_CYC(C), .RAS_CYC(R), .RP_CYC(RP),
    .REFI_CYC(REFI), .PEND_W(PW)
  ) u0 (
    .clk(clk), .rst(rst), .refresh_grant(grant), .refresh_req(req),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done), .refresh_busy(busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_to(int n);
    while (cyc < n) step();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int falls;
    logic prev;
    repeat (3) @(negedge clk);
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 init_done", init_done, 0);
    chk("R1 req", req, 0);
    chk("R1 busy", busy, 0);

    rst = 1'b0;
    grant = 1'b1;   // held during power-up: must be ignored (R5)
    cyc = 0;
    for (int n = 1; n <= DONE_AT; n++) begin
      logic exp_ras;
      step();
      if (n < P) begin
        exp_ras = 1'b1;
        chk("R2 ras_n pause", ras_n, exp_ras);
      end else if (n < DONE_AT) begin
        exp_ras = (((n - P) % (R + RP)) < R) ? 1'b0 : 1'b1;
        chk("R3 ras_n wake", ras_n, exp_ras);
      end else begin
        chk("R3 ras_n end", ras_n, 1);
      end
      chk("R3 cas_n", cas_n, 1);
      chk("R4 init_done", init_done, (n >= DONE_AT) ? 1 : 0);
      chk("R5 req", req, 0);
      chk("R5 busy", busy, 0);
    end
    grant = 1'b0;

    run_to(DONE_AT + REFI - 1);
    chk("R6 req early", req, 0);
    step();
    chk("R6 req due", req, 1);

    grant = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      if (i == 0) grant = 1'b0;
      chk("R7 busy", busy, CBR_WAVE[i][3]);
      chk("R7 ras_n", ras_n, CBR_WAVE[i][2]);
      chk("R7 cas_n", cas_n, CBR_WAVE[i][1]);
      chk("R7 req", req, CBR_WAVE[i][0]);
    end

    run_to(140);
    chk("R6 reload early", req, 0);
    step();
    chk("R6 reload due", req, 1);

    run_to(181);
    grant = 1'b1;
    step();
    chk("R8 busy first", busy, 1);
    chk("R8 req kept", req, 1);
    run_to(189);
    chk("R8 idle gap", busy, 0);
    step();
    chk("R8 busy second", busy, 1);
    chk("R8 cas_n second", cas_n, 0);
    chk("R8 req cleared", req, 0);
    grant = 1'b0;

    run_to(391);
    chk("R9 req pending", req, 1);
    grant = 1'b1;
    falls = 0;
    prev = ras_n;
    for (int k = 0; k < 29; k++) begin
      step();
      if (prev && !ras_n) falls++;
      prev = ras_n;
    end
    chk("R9 refresh count", falls, 3);
    chk("R9 req drained", req, 0);

    for (int k = 0; k < 10; k++) begin
      step();
      chk("R10 busy", busy, 0);
      chk("R10 ras_n", ras_n, 1);
      chk("R10 cas_n", cas_n, 1);
    end
    grant = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule